// File: doc/BRIEF.md
# Programmed-I/O Phase Timing Sequencer

This block times one programmed-I/O transfer on a disk-drive style host bus. A transfer is split into three timed phases, always in the same order: address setup, strobe active and strobe recovery. Each phase has its own programmable length. The block asserts an address-valid indication for the whole transfer. It drives a read or a write strobe during the active phase only. In the last clock of the transfer it pulses a completion flag.

All three phase lengths share one run-once down counter. A finite state machine has four named states: IDLE, SETUP, ACTIVE and RECOVER. The transitions between them are:

- IDLE to SETUP, when a request is present.
- SETUP to ACTIVE, on a zero count.
- ACTIVE to RECOVER, on a zero count.
- RECOVER to IDLE, on a zero count.

On every transition into a timed state, a multiplexer selects that state's programmed length and the counter loads it. The counter then counts down to zero and holds there. No phase has a counter of its own.

Top module: `pio_phase_sequencer`

## Requirements
- R1: After reset the block is in IDLE, with address-valid, both strobes and done all low. It stays there while no request is present.
- R2: In IDLE, a high request at a clock edge starts a transfer. In the next cycle address-valid is high and both strobes are low (SETUP).
- R3: A programmed length value N makes its phase last N+1 clocks. SETUP uses the setup value, ACTIVE the active value and RECOVER the recovery value, so a transfer lasts (Ns+1)+(Na+1)+(Nr+1) clocks.
- R4: A strobe is high only during ACTIVE. The write strobe is used when the write flag was 1 at the start of the transfer, and the read strobe when it was 0. The two strobes are never high together.
- R5: Address-valid stays high in every cycle of SETUP, ACTIVE and RECOVER.
- R6: Done is high for exactly one clock, the last clock of RECOVER. The following cycle is IDLE.
- R7: A length value of 0 gives a phase of exactly one clock, so no phase is skipped.
- R8: A request during a transfer has no effect on it. If the request is high in the IDLE cycle after done, the next transfer begins on the following clock, so exactly one IDLE cycle separates the two transfers.
- R9: A length value is taken only when its phase is entered. The write flag is taken only at the start of the transfer. Changing either later does not alter the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Transfer request, taken in IDLE |
| write_i | input | 1 | 1 = write transfer, 0 = read transfer |
| t_setup_i | input | CNT_W | Address setup length minus one |
| t_active_i | input | CNT_W | Strobe active length minus one |
| t_recover_i | input | CNT_W | Strobe recovery length minus one |
| addr_valid_o | output | 1 | Address valid for the whole transfer |
| rd_strobe_o | output | 1 | Read strobe |
| wr_strobe_o | output | 1 | Write strobe |
| done_o | output | 1 | One-clock completion pulse |

## Verification
The assertions check on every cycle that the two strobes are mutually exclusive and only appear under address-valid. They also check that done is followed by IDLE, that a request in IDLE always leads into SETUP, and that the shared counter only steps down by one or holds at zero. Only the bench scenarios can show the exact phase lengths for given programmed values. The same holds for the one-clock phases from zero values, the single IDLE gap between back-to-back transfers, and the fact that mid-transfer changes to a request, length or write flag leave the running transfer unchanged.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_SETUP   = 2'd1,
        PH_ACTIVE  = 2'd2,
        PH_RECOVER = 2'd3
    } pio_phase_e;

endpackage

// File: rtl/pio_down_counter.sv
module pio_down_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign zero_o = (cnt_q == '0);

    // R3: a running count steps down by exactly one
    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R3: run-once behaviour, the count holds at zero until reloaded
    assert_hold_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/pio_load_mux.sv
module pio_load_mux
    import pio_seq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  pio_phase_e       phase_i,
    input  logic [CNT_W-1:0] t_setup_i,
    input  logic [CNT_W-1:0] t_active_i,
    input  logic [CNT_W-1:0] t_recover_i,
    output logic [CNT_W-1:0] val_o
);

    always_comb begin
        unique case (phase_i)
            PH_IDLE:    val_o = '0;
            PH_SETUP:   val_o = t_setup_i;
            PH_ACTIVE:  val_o = t_active_i;
            PH_RECOVER: val_o = t_recover_i;
        endcase
    end

endmodule

// File: rtl/pio_phase_sequencer.sv
module pio_phase_sequencer
    import pio_seq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             write_i,
    input  logic [CNT_W-1:0] t_setup_i,
    input  logic [CNT_W-1:0] t_active_i,
    input  logic [CNT_W-1:0] t_recover_i,
    output logic             addr_valid_o,
    output logic             rd_strobe_o,
    output logic             wr_strobe_o,
    output logic             done_o
);

    pio_phase_e       state_q, state_d;
    logic             write_q;
    logic             load;
    logic             cnt_zero;
    logic [CNT_W-1:0] load_val;

    // Next-state and counter-load decision
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            PH_IDLE: if (req_i) begin
                state_d = PH_SETUP;
                load    = 1'b1;
            end
            PH_SETUP: if (cnt_zero) begin
                state_d = PH_ACTIVE;
                load    = 1'b1;
            end
            PH_ACTIVE: if (cnt_zero) begin
                state_d = PH_RECOVER;
                load    = 1'b1;
            end
            PH_RECOVER: if (cnt_zero) begin
                state_d = PH_IDLE;
            end
        endcase
    end

    // State register and transfer direction capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            write_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == PH_IDLE && req_i) begin
                write_q <= write_i;
            end
        end
    end

    pio_load_mux #(.CNT_W(CNT_W)) u_mux (
        .phase_i     (state_d),
        .t_setup_i   (t_setup_i),
        .t_active_i  (t_active_i),
        .t_recover_i (t_recover_i),
        .val_o       (load_val)
    );

    pio_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (load_val),
        .zero_o     (cnt_zero)
    );

    // Outputs
    always_comb begin
        addr_valid_o = 1'b0;
        rd_strobe_o  = 1'b0;
        wr_strobe_o  = 1'b0;
        done_o       = 1'b0;
        unique case (state_q)
            PH_IDLE: ;
            PH_SETUP:   addr_valid_o = 1'b1;
            PH_ACTIVE: begin
                addr_valid_o = 1'b1;
                rd_strobe_o  = !write_q;
                wr_strobe_o  = write_q;
            end
            PH_RECOVER: begin
                addr_valid_o = 1'b1;
                done_o       = cnt_zero;
            end
        endcase
    end

    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_strobe_o && wr_strobe_o));

    assert_strobe_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe_o || wr_strobe_o) |-> addr_valid_o);

    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !addr_valid_o));

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_valid_o && req_i) |=> (addr_valid_o && !rd_strobe_o && !wr_strobe_o));

endmodule

// File: tb/pio_phase_sequencer_tb.sv
module pio_phase_sequencer_tb;

    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_i = 1'b0;
    logic             write_i = 1'b0;
    logic [CNT_W-1:0] t_setup_i = '0;
    logic [CNT_W-1:0] t_active_i = '0;
    logic [CNT_W-1:0] t_recover_i = '0;
    logic             addr_valid_o, rd_strobe_o, wr_strobe_o, done_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pio_phase_sequencer #(.CNT_W(CNT_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req_i),
        .write_i      (write_i),
        .t_setup_i    (t_setup_i),
        .t_active_i   (t_active_i),
        .t_recover_i  (t_recover_i),
        .addr_valid_o (addr_valid_o),
        .rd_strobe_o  (rd_strobe_o),
        .wr_strobe_o  (wr_strobe_o),
        .done_o       (done_o)
    );

    function automatic logic [3:0] exp_out(input int ph, input logic w, input logic last);
        // ph: 0 idle, 1 setup, 2 active, 3 recovery; packed {av, rd, wr, done}
        return {ph != 0, ph == 2 && !w, ph == 2 && w, ph == 3 && last};
    endfunction

    task automatic check(input string rq, input logic [3:0] exp);
        logic [3:0] act;
        act = {addr_valid_o, rd_strobe_o, wr_strobe_o, done_o};
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: {av,rd,wr,done} actual %b expected %b", rq, $time, act, exp);
        end
    endtask

    // Entered at a negedge in IDLE; leaves at the negedge of the IDLE cycle after done.
    task automatic do_cycle(input int ts, input int ta, input int tr, input logic w,
                            input logic hold, input logic chg, input string rq);
        int len;
        req_i       = 1'b1;
        write_i     = w;
        t_setup_i   = CNT_W'(ts);
        t_active_i  = CNT_W'(ta);
        t_recover_i = CNT_W'(tr);
        for (int p = 1; p <= 3; p++) begin
            len = (p == 1 ? ts : (p == 2 ? ta : tr)) + 1;
            for (int k = 0; k < len; k++) begin
                @(negedge clk);
                if (p == 1 && k == 0) write_i = ~w;           // R9: direction already taken
                if (!hold) req_i = (p == 2 && k == 0);         // R8: stray request mid-transfer
                if (chg && p == 2 && k == 0) begin             // R9: late length changes
                    t_active_i = CNT_W'($urandom_range(0, 9));
                    t_setup_i  = CNT_W'($urandom_range(0, 9));
                end
                check(rq, exp_out(p, w, k == len - 1));
            end
        end
        @(negedge clk);
        check({rq, " R6 idle after done"}, exp_out(0, w, 1'b0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check("R1 in reset", 4'b0000);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R1 idle without request", 4'b0000);
        end
        do_cycle(2, 3, 1, 1'b0, 1'b0, 1'b0, "R3 R4 read transfer");
        do_cycle(1, 4, 2, 1'b1, 1'b0, 1'b0, "R3 R4 write transfer");
        do_cycle(0, 0, 0, 1'b1, 1'b0, 1'b0, "R7 all-zero lengths");
        do_cycle(0, 5, 0, 1'b0, 1'b1, 1'b0, "R8 held request");
        do_cycle(3, 0, 4, 1'b1, 1'b1, 1'b0, "R8 back-to-back");
        do_cycle(2, 2, 2, 1'b0, 1'b0, 1'b1, "R9 mid-transfer length change");
        do_cycle(255, 1, 255, 1'b1, 1'b0, 1'b1, "R3 R5 maximum lengths");
        for (int i = 0; i < 30; i++) begin
            do_cycle($urandom_range(0, 6), $urandom_range(0, 6), $urandom_range(0, 6),
                     1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     1'($urandom_range(0, 1)), "R2 R3 R4 R5 R6 random transfer");
        end
        req_i = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R1 idle at end", 4'b0000);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule